// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block produces the column address for each beat of a read or write burst in a synchronous DRAM, following the settings held in a stored mode register. A mode load strobe captures an 11-bit operand into that register. A start strobe carries the first column and a read/write flag, and the block then steps through the burst. The burst ends when its last beat has been presented, when a stop strobe arrives, or when a new start takes its place.

The burst can be 1, 2, 4 or 8 beats, or a full 256-column page. Short bursts walk through their aligned block either by counting upward and wrapping, or by XOR-ing the beat index into the low bits of the start column. A mode bit can limit write bursts to a single column while read bursts keep the programmed length. When the clock enable is low, the sequence holds its position and every strobe is ignored.

Top module: `sdram_col_seq`

## Requirements
- R1: Reset clears the mode register to all zeros, which gives one-beat sequential bursts. A mode load is taken only on an edge where `cke` is high. The new mode governs bursts that start on later edges.
- R2: The length code in operand bits 2:0 selects the number of beats: 000 gives 1, 001 gives 2, 010 gives 4 and 011 gives 8.
- R3: With operand bit 3 low (sequential order), beat i presents the block base plus ((start offset + i) mod length). For example, a 4-beat burst that starts at column 2 gives 2, 3, 0, 1.
- R4: With operand bit 3 high (interleaved order), beat i presents the block base plus (start offset XOR i). For example, an 8-beat burst that starts at 5 gives 5, 4, 7, 6, 1, 0, 3, 2.
- R5: Length code 111 with sequential order gives a 256-beat burst that counts upward and wraps from column 255 to column 0.
- R6: When operand bit 9 is set, a burst started with `start_wr` high lasts one beat. A read burst still uses the programmed length.
- R7: A stop strobe taken on an edge with `cke` high, and without a start strobe, ends the active burst. `col_vld` is low after that edge. A stop strobe while no burst is active has no effect.
- R8: While `cke` is low, `col_out`, `col_vld` and `col_last` hold their values and every strobe is ignored. Stepping resumes on the first edge where `cke` is high again.
- R9: A start strobe on an edge with `cke` high begins a new burst at `start_col`, even when a burst is active and even when a stop strobe arrives on the same edge. `col_vld` is high and `col_out` equals the new column after that edge.
- R10: Length codes 100, 101 and 110 are reserved, and so is code 111 with interleaved order. These settings give one-beat bursts and drive `mode_err` high while they are stored.
- R11: `col_last` is high exactly on the final beat of a burst that runs to its full length. When no new start arrives, `col_vld` drops on the next enabled edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cke | input | 1 | Clock enable; low freezes the sequence and ignores strobes |
| mrs_stb | input | 1 | Mode register load strobe |
| mrs_op | input | 11 | Mode operand |
| start_stb | input | 1 | Burst start strobe |
| start_wr | input | 1 | Burst is a write (high) or a read (low) |
| start_col | input | 8 | First column of the burst |
| stop_stb | input | 1 | Burst stop strobe |
| col_out | output | 8 | Column for the current beat |
| col_vld | output | 1 | A beat is being presented |
| col_last | output | 1 | Current beat is the final one |
| mode_err | output | 1 | Stored mode holds a reserved length setting |

## Verification
A start or stop strobe, a mode load, or a beat step taken on a rising edge shows at the outputs immediately after that edge, so every result is due one edge after its cause. A mode load therefore first affects a burst that starts on the following edge. The bench drives its inputs on the falling edge. A behavioural model advances on each rising edge from those inputs. The outputs are compared with the model on the next falling edge, half a cycle after the state they depend on has settled.

// File: rtl/sdr_colgen_pkg.sv
package sdr_colgen_pkg;

    localparam int OPW = 11;

    // Order of fields follows the operand bit positions (bit 9 down to 0).
    typedef struct packed {
        logic       wr_single;
        logic [1:0] test_sel;
        logic [2:0] lat_code;
        logic       interleave;
        logic [2:0] len_code;
    } mode_t;

    function automatic logic len_reserved(input logic [2:0] code, input logic ilv);
        logic ok;
        ok = (code[2] == 1'b0) || (code == 3'b111 && !ilv);
        return !ok;
    endfunction

endpackage

// File: rtl/colgen_mode_reg.sv
module colgen_mode_reg
    import sdr_colgen_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cke,
    input  logic             mrs_stb,
    input  logic [OPW-1:0]   mrs_op,
    output mode_t            mode_q,
    output logic [COL_W-1:0] rd_mask,
    output logic             mode_err
);
    logic unused_opbits;
    assign unused_opbits = ^{mrs_op[OPW-1], mode_q.test_sel, mode_q.lat_code};

    always_ff @(posedge clk) begin
        if (rst)
            mode_q <= '0;
        else if (cke && mrs_stb)
            mode_q <= mode_t'(mrs_op[9:0]);
    end

    always_comb begin
        case (mode_q.len_code)
            3'b001:  rd_mask = COL_W'(1);
            3'b010:  rd_mask = COL_W'(3);
            3'b011:  rd_mask = COL_W'(7);
            3'b111:  rd_mask = mode_q.interleave ? '0 : '1;
            default: rd_mask = '0;
        endcase
    end

    assign mode_err = len_reserved(mode_q.len_code, mode_q.interleave);

    p_load_gated_r1: assert property (@(posedge clk) disable iff (rst)
        (!cke && !$past(rst)) |=> $stable(mode_q));

    p_reserved_single_r10: assert property (@(posedge clk) disable iff (rst)
        mode_err |-> (rd_mask == '0));

endmodule

// File: rtl/colgen_beat_ctr.sv
module colgen_beat_ctr #(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cke,
    input  logic             start_stb,
    input  logic             start_wr,
    input  logic [COL_W-1:0] start_col,
    input  logic             stop_stb,
    input  logic [COL_W-1:0] rd_mask,
    input  logic             wr_single,
    input  logic             interleave,
    output logic             vld,
    output logic             last,
    output logic [COL_W-1:0] idx,
    output logic [COL_W-1:0] mask_q,
    output logic [COL_W-1:0] base_col,
    output logic             ilv_q
);
    assign last = vld && (idx == mask_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            vld      <= 1'b0;
            idx      <= '0;
            mask_q   <= '0;
            base_col <= '0;
            ilv_q    <= 1'b0;
        end else if (cke) begin
            if (start_stb) begin
                vld      <= 1'b1;
                idx      <= '0;
                base_col <= start_col;
                mask_q   <= (start_wr && wr_single) ? '0 : rd_mask;
                ilv_q    <= interleave;
            end else if (vld) begin
                if (stop_stb || last)
                    vld <= 1'b0;
                else
                    idx <= idx + COL_W'(1);
            end
        end
    end

    p_freeze_r8: assert property (@(posedge clk) disable iff (rst)
        (!cke && !$past(rst)) |=> ($stable(idx) && $stable(vld)));

    p_stop_ends_r7: assert property (@(posedge clk) disable iff (rst)
        (cke && stop_stb && !start_stb) |=> !vld);

    p_last_ends_r11: assert property (@(posedge clk) disable iff (rst)
        (cke && last && !start_stb) |=> !vld);

endmodule

// File: rtl/colgen_addr_gen.sv
module colgen_addr_gen #(
    parameter int COL_W = 8
) (
    input  logic [COL_W-1:0] base_col,
    input  logic [COL_W-1:0] idx,
    input  logic [COL_W-1:0] mask,
    input  logic             interleave,
    output logic [COL_W-1:0] col
);
    logic [COL_W-1:0] sum;
    assign sum = base_col + idx;

    // Bits inside the burst block move; bits above it stay at the start column.
    for (genvar b = 0; b < COL_W; b++) begin : g_bit
        assign col[b] = mask[b] ? (interleave ? (base_col[b] ^ idx[b]) : sum[b])
                                : base_col[b];
    end

endmodule

// File: rtl/sdram_col_seq.sv
module sdram_col_seq
    import sdr_colgen_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cke,
    input  logic             mrs_stb,
    input  logic [10:0]      mrs_op,
    input  logic             start_stb,
    input  logic             start_wr,
    input  logic [COL_W-1:0] start_col,
    input  logic             stop_stb,
    output logic [COL_W-1:0] col_out,
    output logic             col_vld,
    output logic             col_last,
    output logic             mode_err
);
    mode_t            mode_q;
    logic [COL_W-1:0] rd_mask, idx, mask_q, base_col;
    logic             ilv_q;

    colgen_mode_reg #(.COL_W(COL_W)) u_mode (
        .clk(clk), .rst(rst), .cke(cke), .mrs_stb(mrs_stb), .mrs_op(mrs_op),
        .mode_q(mode_q), .rd_mask(rd_mask), .mode_err(mode_err)
    );

    colgen_beat_ctr #(.COL_W(COL_W)) u_ctr (
        .clk(clk), .rst(rst), .cke(cke), .start_stb(start_stb),
        .start_wr(start_wr), .start_col(start_col), .stop_stb(stop_stb),
        .rd_mask(rd_mask), .wr_single(mode_q.wr_single),
        .interleave(mode_q.interleave), .vld(col_vld), .last(col_last),
        .idx(idx), .mask_q(mask_q), .base_col(base_col), .ilv_q(ilv_q)
    );

    colgen_addr_gen #(.COL_W(COL_W)) u_addr (
        .base_col(base_col), .idx(idx), .mask(mask_q),
        .interleave(ilv_q), .col(col_out)
    );

    p_start_loads_r9: assert property (@(posedge clk) disable iff (rst)
        (cke && start_stb) |=> (col_vld && col_out == $past(start_col)));

    p_last_in_burst_r11: assert property (@(posedge clk) disable iff (rst)
        col_last |-> col_vld);

    p_out_frozen_r8: assert property (@(posedge clk) disable iff (rst)
        (!cke && !$past(rst)) |=> $stable(col_out));

endmodule

// File: tb/test_sdram_col_seq.sv
module test_sdram_col_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cke = 1'b1;
    logic        mrs_stb = 1'b0;
    logic [10:0] mrs_op = '0;
    logic        start_stb = 1'b0;
    logic        start_wr = 1'b0;
    logic [7:0]  start_col = '0;
    logic        stop_stb = 1'b0;
    logic [7:0]  col_out;
    logic        col_vld, col_last, mode_err;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;
    bit running = 1'b0;
    string cur_req = "R1";

    always #4 clk = ~clk;

    sdram_col_seq i_sdram_col_seq (
        .clk(clk), .rst(rst), .cke(cke), .mrs_stb(mrs_stb), .mrs_op(mrs_op),
        .start_stb(start_stb), .start_wr(start_wr), .start_col(start_col),
        .stop_stb(stop_stb), .col_out(col_out), .col_vld(col_vld),
        .col_last(col_last), .mode_err(mode_err)
    );

    // Behavioural reference model
    int m_mode = 0;
    bit m_act = 0;
    int m_start = 0, m_idx = 0, m_len = 1;
    bit m_ilv = 0;

    function automatic int beats(input int mode);
        int code = mode & 7;
        bit t = (mode >> 3) & 1;
        case (code)
            0: return 1;
            1: return 2;
            2: return 4;
            3: return 8;
            7: return t ? 1 : 256;
            default: return 1;
        endcase
    endfunction

    function automatic bit is_err(input int mode);
        int code = mode & 7;
        bit t = (mode >> 3) & 1;
        return !(code <= 3 || (code == 7 && !t));
    endfunction

    function automatic int exp_col();
        int base = m_start - (m_start % m_len);
        int off = m_start % m_len;
        if (m_ilv) return base + (off ^ m_idx);
        return base + ((off + m_idx) % m_len);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_mode = 0; m_act = 0; m_idx = 0; m_start = 0; m_len = 1; m_ilv = 0;
        end else if (cke) begin
            if (start_stb) begin
                m_act = 1; m_idx = 0; m_start = start_col;
                m_len = (start_wr && ((m_mode >> 9) & 1)) ? 1 : beats(m_mode);
                m_ilv = (m_mode >> 3) & 1;
            end else if (m_act) begin
                if (stop_stb || m_idx == m_len - 1) m_act = 0;
                else m_idx++;
            end
            if (mrs_stb) m_mode = mrs_op;
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (running && !rst) begin
            check(cur_req, "col_vld", col_vld, m_act);
            if (m_act) begin
                check(cur_req, "col_out", col_out, exp_col());
                check("R11", "col_last", col_last, m_idx == m_len - 1);
            end
            check("R10", "mode_err", mode_err, is_err(m_mode));
        end
    end

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d expected below 5000 cycles", cycles);
            report();
        end
    end

    task automatic tick(input bit m, input int op, input bit s, input bit w,
                        input int c, input bit p, input bit k);
        mrs_stb = m; mrs_op = 11'(op); start_stb = s; start_wr = w;
        start_col = 8'(c); stop_stb = p; cke = k;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick(0, 0, 0, 0, 0, 0, 1);
    endtask

    task automatic load(input int op);
        tick(1, op, 0, 0, 0, 0, 1);
    endtask

    task automatic go(input int c, input bit w);
        tick(0, 0, 1, w, c, 0, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "reset col_vld", col_vld, 0);
        check("R1", "reset mode_err", mode_err, 0);
        rst = 1'b0;
        running = 1'b1;
        @(negedge clk);

        cur_req = "R1";
        go(5, 0); idle(2);                    // default mode: one beat
        tick(1, 'h002, 0, 0, 0, 0, 0);        // load ignored while cke low
        go(2, 0); idle(2);

        cur_req = "R3";
        load('h002); go(2, 0); idle(5);       // 2,3,0,1
        cur_req = "R2";
        load('h001); go(7, 0); idle(3);
        load('h003); go('h13, 0); idle(9);
        load('h000); go('h21, 0); idle(2);

        cur_req = "R4";
        load('h00B); go(5, 0); idle(9);       // 5,4,7,6,1,0,3,2
        go('h2E, 0); idle(9);
        load('h00A); go('h31, 0); idle(5);

        cur_req = "R5";
        load('h007); go('hFE, 0); idle(258);

        cur_req = "R6";
        load('h203); go('h44, 1); idle(3);
        go('h44, 0); idle(9);

        cur_req = "R7";
        load('h003); go('h20, 0); idle(2);
        tick(0, 0, 0, 0, 0, 1, 1); idle(3);
        tick(0, 0, 0, 0, 0, 1, 1); idle(2);   // stop with no burst

        cur_req = "R8";
        go('h30, 0); idle(1);
        tick(0, 0, 1, 0, 'h55, 0, 0);
        tick(0, 0, 0, 0, 0, 1, 0);
        tick(1, 'h000, 0, 0, 0, 0, 0);
        idle(9);

        cur_req = "R9";
        go('h40, 0); idle(2);
        go('h66, 0); idle(3);
        tick(0, 0, 1, 0, 'h7A, 1, 1); idle(9);

        cur_req = "R10";
        load('h004); go(9, 0); idle(2);
        load('h00F); go(9, 0); idle(2);
        load('h006); go('h1C, 0); idle(2);
        load('h002); go('h1C, 0); idle(5);

        running = 1'b0;
        report();
    end
endmodule